// File: doc/BRIEF.md
# Command-Byte Serial Register Interface

This block is a synchronous serial slave. A host uses it to read and write a bank of internal registers whose widths differ by address. The serial pins (active-low chip select, serial clock, data in, data out) are asynchronous to the block clock. Each of them passes through a synchronizer of configurable depth, and the block finds the serial clock edges in the block clock domain.

A transaction opens with an 8-bit command byte. Its top bit gives the direction and its low seven bits give the register address. An internal length decoder maps the address to a register width and an access right. The block then moves exactly as many whole bytes as that width needs, most significant byte first. A 12-bit register takes two bytes. Reads fetch the word from the bank when the command completes and shift it out. Writes collect all data bytes, then commit them to the bank in a single strobe.

Top module: `cri_serial_if`

## Requirements
- R1: The command byte is sampled MSB first on falling SCLK edges while CS_n is low; bit 7 = 1 selects a write, bit 7 = 0 a read, and bits 6:0 are the register address.
- R2: Register width and access by address: 0x00–0x0F 24-bit read-only; 0x10 12-bit read-only; 0x11 8-bit read-only; 0x12 24-bit read-only; 0x13–0x17 8-bit read/write; 0x18 24-bit read/write; 0x19–0x1A 24-bit read-only; 0x1B–0x44 12-bit read/write; 0x45 and 0x47 16-bit read/write; 0x46 and 0x48 12-bit read/write; 0x49–0x7F 8-bit read-only. An 8-bit register uses 1 data byte, a 12- or 16-bit register 2, and a 24-bit register 3.
- R3: On a read, the register value is right-justified in its byte count, with unused upper bits zero. It is sent MSB first, and each new bit appears on dout_o after a rising SCLK edge. The first bit follows the rising edge after the eighth command bit.
- R4: On a write, data bits are sampled on falling SCLK edges, MSB first. After the last data bit, reg_we_o pulses for exactly one clock cycle with reg_addr_o set to the address and reg_wdata_o set to the value right-justified. Bits above the register width are discarded, so for a 12-bit register the upper 4 bits of the first byte are dropped.
- R5: A write to a read-only address produces no reg_we_o pulse.
- R6: If CS_n rises before the last bit of a transfer, no write occurs. The next transfer starts again with a command byte.
- R7: dout_oe_o is low (DOUT high impedance) whenever CS_n is high and high while CS_n is low.
- R8: After reset, reg_we_o and dout_o are low.
- R9: SCLK edges after the final data byte and before CS_n rises cause no further write and do not change dout_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock, idles high |
| din_i | input | 1 | Serial data from host |
| dout_o | output | 1 | Serial data to host |
| dout_oe_o | output | 1 | Output enable for the DOUT pad; low means high impedance |
| reg_addr_o | output | 7 | Register bank address |
| reg_wdata_o | output | 24 | Register bank write data, right-justified |
| reg_we_o | output | 1 | Register bank write strobe, one cycle |
| reg_rdata_i | input | 24 | Register bank read data for reg_addr_o |

## Verification
The bench builds the block with a three-stage synchronizer, a depth above the default. Each SCLK half period lasts six block clocks, which is enough for the edge detector, the deeper synchronizer and the read-data load to settle before the host samples. At that depth the bench covers every width class and both access rights. It also covers 12-bit padding on writes and reads, aborts during both the command and the data phase, and surplus clocks after a complete frame.

// File: rtl/cri_pkg.sv
package cri_pkg;
  localparam int ADDR_W    = 7;
  localparam int MAX_BYTES = 3;
  localparam int DATA_W    = 8 * MAX_BYTES;
  localparam int CNT_W     = $clog2(MAX_BYTES);

  typedef enum logic [1:0] {LEN_8, LEN_12, LEN_16, LEN_24} len_e;

  function automatic logic [CNT_W-1:0] last_byte(len_e l);
    case (l)
      LEN_8:          return CNT_W'(0);
      LEN_12, LEN_16: return CNT_W'(1);
      default:        return CNT_W'(2);
    endcase
  endfunction

  // right-justify and clear bits above width
  function automatic logic [DATA_W-1:0] fit_right(logic [DATA_W-1:0] d, len_e l);
    case (l)
      LEN_8:   return {16'h0, d[7:0]};
      LEN_12:  return {12'h0, d[11:0]};
      LEN_16:  return {8'h0, d[15:0]};
      default: return d;
    endcase
  endfunction

  // place used bytes at the top of the shift register
  function automatic logic [DATA_W-1:0] pack_left(logic [DATA_W-1:0] d, len_e l);
    case (l)
      LEN_8:   return {d[7:0], 16'h0};
      LEN_12:  return {4'h0, d[11:0], 8'h0};
      LEN_16:  return {d[15:0], 8'h0};
      default: return d;
    endcase
  endfunction
endpackage

// File: rtl/cri_sync.sv
module cri_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) stg[0] <= RST_VAL;
    else         stg[0] <= d_i;

  for (genvar g = 1; g < STAGES; g++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) stg[g] <= RST_VAL;
      else         stg[g] <= stg[g-1];
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/cri_len_dec.sv
module cri_len_dec
  import cri_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output len_e              len_o,
  output logic              ro_o
);
  always_comb begin
    len_o = LEN_8;
    ro_o  = 1'b1;
    if (addr_i <= 7'h0F)                         begin len_o = LEN_24; ro_o = 1'b1; end
    else if (addr_i == 7'h10)                    begin len_o = LEN_12; ro_o = 1'b1; end
    else if (addr_i == 7'h11)                    begin len_o = LEN_8;  ro_o = 1'b1; end
    else if (addr_i == 7'h12)                    begin len_o = LEN_24; ro_o = 1'b1; end
    else if (addr_i <= 7'h17)                    begin len_o = LEN_8;  ro_o = 1'b0; end
    else if (addr_i == 7'h18)                    begin len_o = LEN_24; ro_o = 1'b0; end
    else if (addr_i <= 7'h1A)                    begin len_o = LEN_24; ro_o = 1'b1; end
    else if (addr_i <= 7'h44)                    begin len_o = LEN_12; ro_o = 1'b0; end
    else if (addr_i == 7'h45 || addr_i == 7'h47) begin len_o = LEN_16; ro_o = 1'b0; end
    else if (addr_i == 7'h46 || addr_i == 7'h48) begin len_o = LEN_12; ro_o = 1'b0; end
    else                                         begin len_o = LEN_8;  ro_o = 1'b1; end
  end
endmodule

// File: rtl/cri_engine.sv
module cri_engine
  import cri_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,      // synchronized, high = idle
  input  logic              fall_i,
  input  logic              rise_i,
  input  logic              din_i,
  input  len_e              len_i,
  input  logic              ro_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              we_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              dout_o
);
  typedef enum logic [1:0] {ST_CMD, ST_LOAD, ST_DATA, ST_DONE} st_e;

  st_e               st_q;
  logic [2:0]        bit_q;
  logic [CNT_W-1:0]  byte_q;
  logic [DATA_W-1:0] rx_q, tx_q;
  logic              wr_q;
  logic [DATA_W-1:0] rx_nxt;

  assign rx_nxt = {rx_q[DATA_W-2:0], din_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_CMD;
      bit_q   <= '0;
      byte_q  <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      wr_q    <= 1'b0;
      addr_o  <= '0;
      we_o    <= 1'b0;
      wdata_o <= '0;
      dout_o  <= 1'b0;
    end else if (cs_i) begin
      st_q   <= ST_CMD;
      bit_q  <= '0;
      byte_q <= '0;
      we_o   <= 1'b0;
      dout_o <= 1'b0;
    end else begin
      we_o <= 1'b0;
      case (st_q)
        ST_CMD: if (fall_i) begin
          rx_q  <= rx_nxt;
          bit_q <= bit_q + 3'd1;
          if (bit_q == 3'd7) begin
            addr_o <= rx_nxt[ADDR_W-1:0];
            wr_q   <= rx_nxt[7];
            st_q   <= ST_LOAD;
          end
        end
        ST_LOAD: begin // address now settled at the bank
          tx_q   <= pack_left(rdata_i, len_i);
          rx_q   <= '0;
          byte_q <= '0;
          st_q   <= ST_DATA;
        end
        ST_DATA: begin
          if (rise_i && !wr_q) begin
            dout_o <= tx_q[DATA_W-1];
            tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
          end
          if (fall_i) begin
            rx_q  <= rx_nxt;
            bit_q <= bit_q + 3'd1;
            if (bit_q == 3'd7) begin
              byte_q <= byte_q + CNT_W'(1);
              if (byte_q == last_byte(len_i)) begin
                st_q <= ST_DONE;
                if (wr_q && !ro_i) begin
                  we_o    <= 1'b1;
                  wdata_o <= fit_right(rx_nxt, len_i);
                end
              end
            end
          end
        end
        default: ; // ST_DONE: wait for CS_n high
      endcase
    end
  end
endmodule

// File: rtl/cri_serial_if.sv
module cri_serial_if
  import cri_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              din_i,
  output logic              dout_o,
  output logic              dout_oe_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  logic       cs_s, sclk_s, din_s, sclk_q;
  logic       sclk_fall, sclk_rise, ro_w;
  len_e       len_w;

  cri_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, din_i}),
    .q_o   ({cs_s, sclk_s, din_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sclk_q <= 1'b1;
    else         sclk_q <= sclk_s;

  assign sclk_fall = sclk_q & ~sclk_s;
  assign sclk_rise = ~sclk_q & sclk_s;

  cri_len_dec u_len (
    .addr_i(reg_addr_o),
    .len_o (len_w),
    .ro_o  (ro_w)
  );

  cri_engine u_eng (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_i   (cs_s),
    .fall_i (sclk_fall),
    .rise_i (sclk_rise),
    .din_i  (din_s),
    .len_i  (len_w),
    .ro_i   (ro_w),
    .rdata_i(reg_rdata_i),
    .addr_o (reg_addr_o),
    .we_o   (reg_we_o),
    .wdata_o(reg_wdata_o),
    .dout_o (dout_o)
  );

  // pad enable follows the raw select
  assign dout_oe_o = ~cs_ni;
endmodule

// File: rtl/cri_serial_if_chk.sv
module cri_serial_if_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_s,
  input logic sclk_fall,
  input logic sclk_rise,
  input logic ro_w,
  input logic reg_we_o,
  input logic dout_o
);
  a_r4_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  a_r4_strobe_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> $past(sclk_fall));

  a_r5_no_ro_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> !ro_w);

  a_r6_no_write_after_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> !reg_we_o);

  a_r3_dout_moves_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sclk_rise && !cs_s) |=> $stable(dout_o));
endmodule

bind cri_serial_if cri_serial_if_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_s     (cs_s),
  .sclk_fall(sclk_fall),
  .sclk_rise(sclk_rise),
  .ro_w     (ro_w),
  .reg_we_o (reg_we_o),
  .dout_o   (dout_o)
);

// File: tb/tb_cri_serial_if.sv
module tb_cri_serial_if;
  localparam int CLK_P = 10;
  localparam int HALF  = 6;   // block clocks per SCLK half period

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cs_n = 1'b1, sclk = 1'b1, din = 1'b0;
  logic        dout, dout_oe, reg_we;
  logic [6:0]  reg_addr;
  logic [23:0] reg_wdata, reg_rdata;
  logic [23:0] bank [128];
  logic [23:0] mdl  [128];
  logic [30:0] exp_q [$];
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  cri_serial_if #(.SYNC_STAGES(3)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .din_i(din),
    .dout_o(dout), .dout_oe_o(dout_oe), .reg_addr_o(reg_addr),
    .reg_wdata_o(reg_wdata), .reg_we_o(reg_we), .reg_rdata_i(reg_rdata)
  );

  assign reg_rdata = bank[reg_addr];
  always @(posedge clk) if (reg_we) bank[reg_addr] <= reg_wdata;

  task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // widths and access rights per R2
  function automatic int wid(logic [6:0] a);
    if (a <= 7'h0F) return 24;
    if (a == 7'h10) return 12;
    if (a == 7'h11) return 8;
    if (a == 7'h12) return 24;
    if (a <= 7'h17) return 8;
    if (a <= 7'h1A) return 24;
    if (a <= 7'h44) return 12;
    if (a == 7'h45 || a == 7'h47) return 16;
    if (a == 7'h46 || a == 7'h48) return 12;
    return 8;
  endfunction

  function automatic bit rd_only(logic [6:0] a);
    return (a <= 7'h12) || (a == 7'h19) || (a == 7'h1A) || (a >= 7'h49);
  endfunction

  function automatic logic [23:0] msk(logic [23:0] v, int w);
    return v & ((24'h1 << w) - 24'h1) | ((w == 24) ? v : 24'h0);
  endfunction

  // monitor: every strobe must match a queued expectation
  always @(negedge clk) if (rst_n && reg_we) begin
    if (exp_q.size() == 0)
      chk(1'b0, "R5/R6/R9 unexpected strobe", {17'h0, reg_addr}, 24'h0);
    else begin
      logic [30:0] e;
      e = exp_q.pop_front();
      chk({reg_addr, reg_wdata} == e, "R4 write strobe addr/data", reg_wdata, e[23:0]);
      chk(reg_addr == e[30:24], "R1 write address", {17'h0, reg_addr}, {17'h0, e[30:24]});
    end
  end

  // cut < 0: full frame; extra: surplus SCLK cycles after the frame
  task automatic xfer(input bit wr, input logic [6:0] a, input logic [23:0] val,
                      input int cut, input int extra, output logic [23:0] rd);
    int n, total;
    logic [31:0] fr;
    n     = (wid(a) + 7) / 8;
    total = 8 + 8 * n;
    fr    = {wr, a, val << (8 * (3 - n))};
    rd    = '0;
    if (wr && cut < 0 && !rd_only(a)) begin
      exp_q.push_back({a, msk(val, wid(a))});
      mdl[a] = msk(val, wid(a));
    end
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    chk(dout_oe == 1'b1, "R7 oe while selected", {23'h0, dout_oe}, 24'h1);
    for (int i = 0; i < total + extra; i++) begin
      if (cut >= 0 && i == cut) break;
      din = (i < 32) ? fr[31 - i] : 1'b1;
      if (i >= total) din = 1'b1;
      repeat (HALF) @(negedge clk);
      if (i >= 8 && i < total) rd = {rd[22:0], dout};
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    din  = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic wr_t(input logic [6:0] a, input logic [23:0] v);
    logic [23:0] d;
    xfer(1'b1, a, v, -1, 0, d);
  endtask

  task automatic rd_chk(input logic [6:0] a, input string req);
    logic [23:0] d;
    xfer(1'b0, a, 24'h0, -1, 0, d);
    chk(d == msk(mdl[a], wid(a)), req, d, msk(mdl[a], wid(a)));
  endtask

  initial begin
    logic [23:0] d;
    for (int i = 0; i < 128; i++) begin
      bank[i] = 24'h5A5A5A ^ 24'(i * 24'h010203);
      mdl[i]  = bank[i];
    end
    bank[7'h10] = 24'hABC123; mdl[7'h10] = 24'hABC123;
    bank[7'h05] = 24'h89ABCD; mdl[7'h05] = 24'h89ABCD;
    bank[7'h60] = 24'h00005A; mdl[7'h60] = 24'h00005A;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(dout_oe == 1'b0, "R7 oe low when deselected", {23'h0, dout_oe}, 24'h0);
    chk(reg_we == 1'b0, "R8 reset strobe", {23'h0, reg_we}, 24'h0);
    chk(dout == 1'b0, "R8 reset dout", {23'h0, dout}, 24'h0);

    wr_t(7'h13, 24'h0000A5);  rd_chk(7'h13, "R1 R3 8-bit write/read");
    wr_t(7'h45, 24'h00BEEF);  rd_chk(7'h45, "R2 R3 16-bit write/read");
    wr_t(7'h18, 24'h123456);  rd_chk(7'h18, "R2 R3 24-bit write/read");
    wr_t(7'h46, 24'h00F7C3);  rd_chk(7'h46, "R4 12-bit pad dropped");
    rd_chk(7'h10, "R3 12-bit read upper bits zero");
    rd_chk(7'h05, "R2 24-bit read-only read");
    rd_chk(7'h60, "R2 8-bit read-only read");

    wr_t(7'h10, 24'h000FFF);  rd_chk(7'h10, "R5 read-only unchanged");
    wr_t(7'h60, 24'h0000FF);  rd_chk(7'h60, "R5 read-only 8-bit unchanged");

    xfer(1'b1, 7'h14, 24'h0000C3, 12, 0, d);
    rd_chk(7'h14, "R6 abort in data phase");
    xfer(1'b1, 7'h15, 24'h000077, 5, 0, d);
    wr_t(7'h15, 24'h000077);  rd_chk(7'h15, "R6 fresh command after abort");

    xfer(1'b1, 7'h16, 24'h000011, -1, 16, d);
    mdl[7'h16] = 24'h11;
    rd_chk(7'h16, "R9 surplus clocks ignored");
    xfer(1'b0, 7'h45, 24'h0, -1, 10, d);
    chk(d == 24'h00BEEF, "R9 read with surplus clocks", d, 24'h00BEEF);

    chk(exp_q.size() == 0, "R4 all expected strobes seen", 24'(exp_q.size()), 24'h0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule